// File: doc/BRIEF.md
# Dual-Core Debug Lock Controller

This block decides whether the debug ports of two cores on one die may be used. One core is the security core, the other the application core. The block keeps a lock flag per core and drives one JTAG enable per core. It also drives the enable of the mailbox through which the application core reaches the security core. When isolation mode is on, that mailbox is shut.

Lock requests are checked against three things: the current state, a fixed cross-core ordering, and the per-core signature-validation enable. They take effect at once. An unlock that passes its checks starts a handshake. The block raises a one-cycle challenge strobe and then waits for an external authentication result. The cryptography lives outside the block. If no answer comes within a programmable window, the unlock fails. Fuse bits and key-provisioned flags arrive as plain input pins. A core with its fuse blown and no key provisioned can never be unlocked.

Top module: `dbg_lock_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, `stat_lock` takes the value of `fuse_jtag_off`, isolation is cleared, `stat_err` becomes 0, and `busy`, `chal_req` and `err_pulse` are 0.
- R2: Index 0 of every two-bit vector is the security core and index 1 is the application core. `jtag_en[i]` is the inverse of `stat_lock[i]`, independently for each core.
- R3: An accepted lock request sets the core's flag at the request edge. A lock request for a core whose `sig_en` bit is 0 is refused with code 2, and that core stays unlocked.
- R4: Ordering is enforced. A lock request for the security core while the application core is locked is refused with code 1. An unlock request for the security core while the application core is locked is also refused with code 1.
- R5: A request that asks for the state a core already has is refused with code 6. If several refusal reasons apply, code 6 wins over code 1, and code 1 wins over codes 2 and 3.
- R6: When `fuse_jtag_off[i]`=1 and `key_prov[i]`=0, every unlock request for core i is refused with code 3, and no challenge is raised.
- R7: An unlock that passes its checks drives `chal_req` high for exactly the one cycle after the request edge, with `chal_core` naming the core. `busy` stays high until the result. Requests presented while `busy` is high are ignored.
- R8: While `busy` is high, `auth_done`=1 with `auth_ok`=1 clears the core's lock flag at that edge. `auth_done`=1 with `auth_ok`=0 refuses the unlock with code 4.
- R9: With window N = `tmo_cycles`, the unlock fails with code 5 at the Nth edge after the request edge if `auth_done` has not been seen by then. An `auth_done` at that same Nth edge takes precedence over the timeout.
- R10: `iso_req`=1 at an edge turns isolation on only if the security core was locked before that edge; otherwise it is ignored. `mbox_en` is the inverse of `stat_iso`.
- R11: A successful unlock of the security core clears isolation at the same edge, which re-enables the mailbox.
- R12: Every refusal (codes 1 to 6) loads its code into `stat_err` and raises `err_pulse` for one cycle. Accepted operations leave `stat_err` unchanged.
- R13: `auth_done` while `busy` is low changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_core | input | 1 | Target core: 0 security, 1 application |
| req_unlock | input | 1 | 1 for unlock, 0 for lock |
| iso_req | input | 1 | Turn isolation mode on |
| sig_en | input | 2 | Signature validation enabled, per core |
| fuse_jtag_off | input | 2 | JTAG-disable fuse, per core |
| key_prov | input | 2 | Verification key provisioned, per core |
| tmo_cycles | input | TMO_W | Authentication response window in cycles |
| auth_done | input | 1 | Authentication result strobe |
| auth_ok | input | 1 | Authentication passed |
| chal_req | output | 1 | Challenge request strobe |
| chal_core | output | 1 | Core the challenge is for |
| busy | output | 1 | Unlock handshake in progress |
| jtag_en | output | 2 | JTAG port enable, per core |
| mbox_en | output | 1 | Application-to-security mailbox enable |
| stat_lock | output | 2 | Lock flags |
| stat_iso | output | 1 | Isolation mode state |
| stat_err | output | 3 | Sticky last error code |
| err_pulse | output | 1 | One-cycle refusal indication |

## Verification
The bench goes after the ordering corners: locking the security core after the application core, and unlocking the security core first. A design that enforced no order would lock or unlock anyway and leave `stat_err` untouched. It hits the exact last cycle of the response window, where a response must still win. An off-by-one counter would report code 5 or take one cycle too many. It also covers the permanently locked core, a request landing mid-handshake, and an isolation request while the security core is open. A design that got these wrong would raise a challenge it must not raise, start a second handshake, or shut the mailbox with nothing left to protect.

// File: rtl/dbg_lock_pkg.sv
package dbg_lock_pkg;

    localparam int NCORE = 2;
    localparam logic CORE_SEC = 1'b0;
    localparam logic CORE_APP = 1'b1;

    typedef enum logic [2:0] {
        ERR_NONE  = 3'd0,
        ERR_ORDER = 3'd1,
        ERR_NOSIG = 3'd2,
        ERR_PERM  = 3'd3,
        ERR_AUTH  = 3'd4,
        ERR_TMO   = 3'd5,
        ERR_STATE = 3'd6
    } err_e;

    typedef struct packed {
        logic valid;
        logic unlock;
        logic core;
    } req_t;

    typedef struct packed {
        logic lock_go;
        logic unlock_go;
        err_e err;
        logic core;
    } verdict_t;

    function automatic logic perm_locked(input logic fuse, input logic key);
        return fuse & ~key;
    endfunction

    function automatic err_e judge_lock(input logic core, input logic [NCORE-1:0] lock,
                                        input logic sig);
        if (lock[core])                        return ERR_STATE;
        if (core == CORE_SEC && lock[CORE_APP]) return ERR_ORDER;
        if (!sig)                              return ERR_NOSIG;
        return ERR_NONE;
    endfunction

    function automatic err_e judge_unlock(input logic core, input logic [NCORE-1:0] lock,
                                          input logic perm);
        if (!lock[core])                       return ERR_STATE;
        if (core == CORE_SEC && lock[CORE_APP]) return ERR_ORDER;
        if (perm)                              return ERR_PERM;
        return ERR_NONE;
    endfunction

endpackage

// File: rtl/dbg_req_check.sv
module dbg_req_check
    import dbg_lock_pkg::*;
(
    input  req_t                   req,
    input  logic                   idle,
    input  logic [NCORE-1:0]       lock,
    input  logic [NCORE-1:0]       sig_en,
    input  logic [NCORE-1:0]       perm,
    output verdict_t               verdict
);

    err_e code;
    logic live;

    always_comb begin
        live = req.valid & idle;
        code = ERR_NONE;
        if (live) begin
            code = req.unlock ? judge_unlock(req.core, lock, perm[req.core])
                              : judge_lock(req.core, lock, sig_en[req.core]);
        end
        verdict           = '0;
        verdict.core      = req.core;
        verdict.err       = code;
        verdict.lock_go   = live & ~req.unlock & (code == ERR_NONE);
        verdict.unlock_go = live &  req.unlock & (code == ERR_NONE);
    end

endmodule

// File: rtl/dbg_auth_hs.sv
module dbg_auth_hs
    import dbg_lock_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          start_core,
    input  logic [TW-1:0] tmo,
    input  logic          auth_done,
    input  logic          auth_ok,
    output logic          busy,
    output logic          chal_req,
    output logic          chal_core,
    output logic          fin_ok,
    output logic          fin_fail,
    output err_e          fin_err
);

    typedef enum logic {HS_IDLE, HS_WAIT} hs_e;

    localparam int CW = TW + 1;

    hs_e           state_q;
    logic [TW-1:0] cnt_q;
    logic          core_q;
    logic          chal_q;
    logic          expire;
    logic          waiting;

    assign waiting = (state_q == HS_WAIT);
    assign expire  = ({1'b0, cnt_q} + CW'(1)) >= {1'b0, tmo};

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= HS_IDLE;
            cnt_q   <= '0;
            core_q  <= 1'b0;
            chal_q  <= 1'b0;
        end else begin
            chal_q <= 1'b0;
            case (state_q)
                HS_IDLE: begin
                    if (start) begin
                        state_q <= HS_WAIT;
                        cnt_q   <= '0;
                        core_q  <= start_core;
                        chal_q  <= 1'b1;
                    end
                end
                default: begin
                    if (auth_done || expire) state_q <= HS_IDLE;
                    else                     cnt_q   <= cnt_q + TW'(1);
                end
            endcase
        end
    end

    assign busy      = waiting;
    assign chal_req  = chal_q;
    assign chal_core = core_q;
    assign fin_ok    = waiting & auth_done & auth_ok;
    assign fin_fail  = waiting & (auth_done ? ~auth_ok : expire);
    assign fin_err   = auth_done ? ERR_AUTH : ERR_TMO;

    // R7
    chal_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        chal_req |=> !chal_req);
    // R7
    chal_in_wait_chk: assert property (@(posedge clk) disable iff (rst)
        chal_req |-> busy);

endmodule

// File: rtl/dbg_lock_regs.sv
module dbg_lock_regs
    import dbg_lock_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NCORE-1:0] fuse,
    input  logic [NCORE-1:0] sig_en,
    input  logic [NCORE-1:0] perm,
    input  logic             lock_go,
    input  logic             lock_core,
    input  logic             unlock_ok,
    input  logic             unlock_core,
    input  logic             iso_req,
    input  logic             rej,
    input  err_e             rej_code,
    output logic [NCORE-1:0] lock_q,
    output logic             iso_q,
    output err_e             err_q,
    output logic             err_pulse
);

    logic sec_opens;
    assign sec_opens = unlock_ok & (unlock_core == CORE_SEC);

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        always_ff @(posedge clk) begin
            if (rst)                                        lock_q[c] <= fuse[c];
            else if (lock_go && lock_core == 1'(c))         lock_q[c] <= 1'b1;
            else if (unlock_ok && unlock_core == 1'(c))     lock_q[c] <= 1'b0;
        end

        // R3
        lock_needs_sig_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(lock_q[c]) |-> $past(sig_en[c]));
        // R6
        perm_hold_chk: assert property (@(posedge clk) disable iff (rst)
            $fell(lock_q[c]) |-> !$past(perm[c]));
    end

    always_ff @(posedge clk) begin
        if (rst)                                  iso_q <= 1'b0;
        else if (sec_opens)                       iso_q <= 1'b0;
        else if (iso_req && lock_q[CORE_SEC])     iso_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q     <= ERR_NONE;
            err_pulse <= 1'b0;
        end else begin
            err_pulse <= rej;
            if (rej) err_q <= rej_code;
        end
    end

    // R4
    sec_lock_order_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_q[CORE_SEC]) |-> !$past(lock_q[CORE_APP]));
    // R4
    sec_unlock_order_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(lock_q[CORE_SEC]) |-> !$past(lock_q[CORE_APP]));
    // R11
    iso_needs_sec_chk: assert property (@(posedge clk) disable iff (rst)
        iso_q |-> lock_q[CORE_SEC]);
    // R12
    err_pulse_code_chk: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> (err_q != ERR_NONE));

endmodule

// File: rtl/dbg_access_map.sv
module dbg_access_map
    import dbg_lock_pkg::*;
(
    input  logic [NCORE-1:0] lock,
    input  logic             iso,
    output logic [NCORE-1:0] jtag_en,
    output logic             mbox_en
);

    for (genvar c = 0; c < NCORE; c++) begin : g_port
        assign jtag_en[c] = ~lock[c];
    end

    assign mbox_en = ~iso;

endmodule

// File: rtl/dbg_lock_ctrl.sv
module dbg_lock_ctrl
    import dbg_lock_pkg::*;
#(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_core,
    input  logic             req_unlock,
    input  logic             iso_req,
    input  logic [1:0]       sig_en,
    input  logic [1:0]       fuse_jtag_off,
    input  logic [1:0]       key_prov,
    input  logic [TMO_W-1:0] tmo_cycles,
    input  logic             auth_done,
    input  logic             auth_ok,
    output logic             chal_req,
    output logic             chal_core,
    output logic             busy,
    output logic [1:0]       jtag_en,
    output logic             mbox_en,
    output logic [1:0]       stat_lock,
    output logic             stat_iso,
    output logic [2:0]       stat_err,
    output logic             err_pulse
);

    req_t             req;
    verdict_t         verdict;
    logic [NCORE-1:0] perm;
    logic [NCORE-1:0] lock_q;
    logic             iso_q;
    err_e             err_q;
    logic             hs_busy;
    logic             fin_ok;
    logic             fin_fail;
    err_e             fin_err;
    logic             rej;
    err_e             rej_code;

    assign req = '{valid: req_valid, unlock: req_unlock, core: req_core};

    for (genvar c = 0; c < NCORE; c++) begin : g_perm
        assign perm[c] = perm_locked(fuse_jtag_off[c], key_prov[c]);
    end

    dbg_req_check u_check (
        .req     (req),
        .idle    (~hs_busy),
        .lock    (lock_q),
        .sig_en  (sig_en),
        .perm    (perm),
        .verdict (verdict)
    );

    dbg_auth_hs #(.TW(TMO_W)) u_hs (
        .clk        (clk),
        .rst        (rst),
        .start      (verdict.unlock_go),
        .start_core (verdict.core),
        .tmo        (tmo_cycles),
        .auth_done  (auth_done),
        .auth_ok    (auth_ok),
        .busy       (hs_busy),
        .chal_req   (chal_req),
        .chal_core  (chal_core),
        .fin_ok     (fin_ok),
        .fin_fail   (fin_fail),
        .fin_err    (fin_err)
    );

    assign rej      = (verdict.err != ERR_NONE) | fin_fail;
    assign rej_code = fin_fail ? fin_err : verdict.err;

    dbg_lock_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .fuse        (fuse_jtag_off),
        .sig_en      (sig_en),
        .perm        (perm),
        .lock_go     (verdict.lock_go),
        .lock_core   (verdict.core),
        .unlock_ok   (fin_ok),
        .unlock_core (chal_core),
        .iso_req     (iso_req),
        .rej         (rej),
        .rej_code    (rej_code),
        .lock_q      (lock_q),
        .iso_q       (iso_q),
        .err_q       (err_q),
        .err_pulse   (err_pulse)
    );

    dbg_access_map u_map (
        .lock    (lock_q),
        .iso     (iso_q),
        .jtag_en (jtag_en),
        .mbox_en (mbox_en)
    );

    assign busy      = hs_busy;
    assign stat_lock = lock_q;
    assign stat_iso  = iso_q;
    assign stat_err  = err_q;

    // R6
    perm_no_chal_chk: assert property (@(posedge clk) disable iff (rst)
        chal_req |-> !perm[chal_core]);
    // R13
    idle_auth_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(busy) && !$past(req_valid) && !$past(iso_req)) |-> $stable(stat_lock) && $stable(stat_err));

endmodule

// File: tb/sim_dbg_lock_ctrl.sv
`timescale 1ns/1ps
module sim_dbg_lock_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 0, req_core = 0, req_unlock = 0, iso_req = 0;
    logic [1:0] sig_en = 2'b11, fuse_jtag_off = 2'b00, key_prov = 2'b11;
    logic [7:0] tmo_cycles = 8'd6;
    logic       auth_done = 0, auth_ok = 0;
    logic       chal_req, chal_core, busy, mbox_en, stat_iso, err_pulse;
    logic [1:0] jtag_en, stat_lock;
    logic [2:0] stat_err;

    always #4 clk = ~clk;

    dbg_lock_ctrl #(.TMO_W(8)) u0 (.*);

    int total = 0, failed = 0, cycles = 0;
    bit ended = 0;

    // reference model state
    bit [1:0] m_lock;
    bit       m_iso, m_busy, m_chal, m_ccore, m_pulse;
    int       m_err, m_cnt;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            total++; failed++;
            $display("FAIL R7 watchdog act=hung exp=done");
            finish_up();
        end
    end

    function automatic int decide(bit core, bit unl);
        if (unl) begin
            if (!m_lock[core]) return 6;
            if (core == 0 && m_lock[1]) return 1;
            if (fuse_jtag_off[core] && !key_prov[core]) return 3;
            return 0;
        end
        if (m_lock[core]) return 6;
        if (core == 0 && m_lock[1]) return 1;
        if (!sig_en[core]) return 2;
        return 0;
    endfunction

    task automatic model_edge();
        bit [1:0] old_lock;
        bit sec_open;
        int code;
        old_lock = m_lock;
        sec_open = 0;
        if (rst) begin
            m_lock = fuse_jtag_off; m_iso = 0; m_err = 0;
            m_busy = 0; m_chal = 0; m_pulse = 0; m_cnt = 0; m_ccore = 0;
            return;
        end
        m_pulse = 0;
        m_chal  = 0;
        if (!m_busy) begin
            if (req_valid) begin
                code = decide(req_core, req_unlock);
                if (code != 0) begin m_err = code; m_pulse = 1; end
                else if (!req_unlock) m_lock[req_core] = 1;
                else begin m_busy = 1; m_chal = 1; m_ccore = req_core; m_cnt = 0; end
            end
        end else if (auth_done) begin
            m_busy = 0;
            if (auth_ok) begin
                m_lock[m_ccore] = 0;
                if (m_ccore == 0) sec_open = 1;
            end else begin m_err = 4; m_pulse = 1; end
        end else if (m_cnt + 1 >= int'(tmo_cycles)) begin
            m_busy = 0; m_err = 5; m_pulse = 1;
        end else m_cnt++;
        if (sec_open) m_iso = 0;
        else if (iso_req && old_lock[0]) m_iso = 1;
    endtask

    task automatic compare(input string tag);
        chk(jtag_en == ~m_lock, {tag, " R2 jtag_en"}, jtag_en, ~m_lock);
        chk(stat_lock == m_lock, {tag, " R1 stat_lock"}, stat_lock, m_lock);
        chk(mbox_en == !m_iso, {tag, " R10 mbox_en"}, mbox_en, !m_iso);
        chk(stat_iso == m_iso, {tag, " R11 stat_iso"}, stat_iso, m_iso);
        chk(stat_err == m_err, {tag, " R12 stat_err"}, stat_err, m_err);
        chk(err_pulse == m_pulse, {tag, " R12 err_pulse"}, err_pulse, m_pulse);
        chk(busy == m_busy, {tag, " R7 busy"}, busy, m_busy);
        chk(chal_req == m_chal, {tag, " R7 chal_req"}, chal_req, m_chal);
        if (m_chal) chk(chal_core == m_ccore, {tag, " R7 chal_core"}, chal_core, m_ccore);
    endtask

    string cur = "R1";

    task automatic cyc();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(cur);
    endtask

    task automatic req(input bit core, input bit unl);
        req_valid = 1; req_core = core; req_unlock = unl;
        cyc();
        req_valid = 0;
    endtask

    task automatic auth(input bit ok);
        auth_done = 1; auth_ok = ok;
        cyc();
        auth_done = 0; auth_ok = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic do_reset();
        rst = 1;
        idle(3);
        rst = 0;
    endtask

    task automatic expect_err(input int code, input string tag);
        chk(stat_err == code, {tag, " direct stat_err"}, stat_err, code);
    endtask

    initial begin
        @(negedge clk);
        cur = "R1"; do_reset();
        chk(stat_lock == 2'b00 && !busy && stat_err == 0, "R1 reset state", stat_lock, 0);
        idle(1);

        cur = "R4 app then sec";
        req(1, 0);
        req(0, 0);
        expect_err(1, "R4");
        chk(stat_lock == 2'b10, "R4 sec stays open", stat_lock, 2'b10);

        cur = "R8 unlock app ok";
        req(1, 1);
        idle(2);
        auth(1);
        chk(stat_lock == 2'b00, "R8 app unlocked", stat_lock, 0);

        cur = "R4 right order";
        req(0, 0);
        req(1, 0);
        chk(jtag_en == 2'b00, "R2 both ports off", jtag_en, 0);
        req(0, 1);
        expect_err(1, "R4 sec unlock early");
        chk(!chal_req, "R4 no challenge", chal_req, 0);

        cur = "R5 same state";
        req(1, 0);
        expect_err(6, "R5");

        cur = "R10 isolation on";
        iso_req = 1; cyc(); iso_req = 0;
        chk(!mbox_en, "R10 mailbox shut", mbox_en, 0);

        cur = "R8 auth fail";
        req(1, 1);
        idle(1);
        auth(0);
        expect_err(4, "R8");

        cur = "R9 timeout";
        req(1, 1);
        idle(6);
        expect_err(5, "R9");
        chk(stat_lock[1] == 1, "R9 still locked", stat_lock[1], 1);

        cur = "R9 last cycle wins";
        req(1, 1);
        // R7: a request in mid handshake is ignored
        req_valid = 1; req_core = 1; req_unlock = 0; cyc(); req_valid = 0;
        idle(4);
        auth(1);
        chk(stat_lock[1] == 0, "R9 last edge response", stat_lock[1], 0);
        expect_err(5, "R9 err unchanged");

        cur = "R13 idle auth";
        auth(1);
        idle(1);
        chk(stat_lock == 2'b01, "R13 no effect", stat_lock, 2'b01);

        cur = "R11 sec open";
        req(0, 1);
        idle(1);
        auth(1);
        chk(stat_iso == 0 && mbox_en, "R11 isolation cleared", stat_iso, 0);

        cur = "R10 iso ignored";
        iso_req = 1; cyc(); iso_req = 0;
        chk(mbox_en == 1, "R10 mailbox stays open", mbox_en, 1);

        cur = "R3 no sig";
        sig_en = 2'b01;
        req(1, 0);
        expect_err(2, "R3");
        chk(stat_lock[1] == 0, "R3 not locked", stat_lock[1], 0);
        sig_en = 2'b11;

        cur = "R6 permanent";
        fuse_jtag_off = 2'b01; key_prov = 2'b10;
        do_reset();
        chk(stat_lock == 2'b01, "R1 fuse loaded", stat_lock, 2'b01);
        req(0, 1);
        expect_err(3, "R6");
        chk(!busy && !chal_req, "R6 no handshake", busy, 0);
        cur = "R9 zero window";
        fuse_jtag_off = 2'b01; key_prov = 2'b11; tmo_cycles = 0;
        req(0, 1);
        idle(1);
        expect_err(5, "R9 zero window");
        idle(2);
        finish_up();
    end

endmodule